// File: doc/BRIEF.md
# Platform Power-On Reset Sequencer

This block brings a platform out of reset in a fixed order once its supply has settled. It watches a power-stable indication and drives four outputs. A power-good flag rises only after a long stable interval. An active-low system reset follows a millisecond later. Two further releases then run side by side: a core reset that waits for a clock-alignment strobe plus a short fixed window, and an active-low processor bus reset that waits for both a millisecond timer and a link-handshake-done flag. All delays are counted in cycles of a single reference clock, and a parameter sets how many cycles make one millisecond.

All three asynchronous inputs pass through two-flop synchronizers before the state machine sees them. If power becomes unstable at any point, the sequencer drops power-good, asserts every reset, clears its timers and starts again from the beginning. A sequence-done flag shows that every reset has been released, and a two-bit state output exposes the sequencing phase. All pins are plain level signals. No data flows through the block, so it has no valid/ready handshake and nothing can apply back-pressure to it.

Top module: `por_sequencer`

## Requirements
- R1: With power-stable held high, power-good rises exactly 2*CYC_PER_MS+3 clock cycles after the input rises. This is 2*CYC_PER_MS+1 cycles of synchronized stable power plus two cycles of synchronizer latency. A low pulse on the input before that point restarts the count.
- R2: The system reset (active low) is released exactly CYC_PER_MS cycles after power-good rises, and it is never released while power-good is low.
- R3: Core reset (active high) stays asserted after the system reset is released until an alignment strobe has been sampled in that phase. A strobe seen earlier in the sequence does not count.
- R4: Core reset is released CORE_DLY cycles after the first synchronized alignment strobe of the release phase is sampled. This is CORE_DLY+2 cycles after the strobe input is driven. CORE_DLY is clamped to the range 4..6 and defaults to 5. With the strobe present at the system-reset release, the window is exactly CORE_DLY cycles.
- R5: The processor bus reset (active low) is released at the later of two points: CYC_PER_MS cycles after the system reset is released, and 3 cycles after the handshake-done input is driven high. It is never released before the system reset.
- R6: The state output encodes 0 = waiting for stable power, 1 = holding system reset, 2 = releasing core and bus resets, 3 = done. The sequence-done output is high exactly when the state is 3, which is the cycle in which the last reset is released.
- R7: Exactly 3 cycles after power-stable falls, power-good is low, all resets are asserted and the state is 0. After the input recovers, the full sequence runs again with the same delays.
- R8: While rst_n is low, power-good is low, the system and bus resets are low, core reset is high, sequence-done is low and the state is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that times every delay |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer itself |
| pwr_stable_i | input | 1 | Asynchronous power-stable indication |
| clk_align_i | input | 1 | Asynchronous strobe marking a common rising edge of the internal clocks |
| link_done_i | input | 1 | Asynchronous link-handshake-done flag |
| pwr_good_o | output | 1 | Power-good, high once power has been stable long enough |
| sys_rst_n_o | output | 1 | System reset, active low |
| core_rst_o | output | 1 | Core reset, active high |
| bus_rst_n_o | output | 1 | Processor bus reset, active low |
| seq_done_o | output | 1 | High once every reset has been released |
| state_o | output | 2 | Current sequencing phase |

## Verification
The bench sweeps every alignment-strobe arrival from 0 to 6 cycles and every handshake arrival from 0 to 12 cycles after the system reset is released. This covers both sides of the point where the handshake, rather than the millisecond timer, sets the bus-reset release. A design that used only the timer or only the handshake would release the bus reset at the wrong cycle in half of these runs. A design that counted the core window from the system-reset release instead of the strobe would release core reset early whenever the strobe comes late. Every run ends with a power loss, and a single-cycle power glitch is injected during the stable count. A design that failed to clear its counters would raise power-good early on the next attempt or leave a reset released.

// File: rtl/por_pkg.sv
package por_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_PWR = 2'd0,
    ST_SYS_HOLD = 2'd1,
    ST_RELEASE  = 2'd2,
    ST_DONE     = 2'd3
  } seq_state_t;
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic stg1, stg2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg1 <= 1'b0;
        stg2 <= 1'b0;
      end else begin
        stg1 <= d_i[g];
        stg2 <= stg1;
      end
    end
    assign q_o[g] = stg2;
  end
endmodule

// File: rtl/por_timer.sv
module por_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  logic [CW-1:0] cnt;

  // hit marks the enabled cycle that completes LIMIT counts
  assign hit = en && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (hit)    cnt <= '0;
    else if (en)     cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/por_sequencer.sv
module por_sequencer
  import por_pkg::*;
#(
  parameter int CYC_PER_MS = 1000,
  parameter int CORE_DLY   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_stable_i,
  input  logic       clk_align_i,
  input  logic       link_done_i,
  output logic       pwr_good_o,
  output logic       sys_rst_n_o,
  output logic       core_rst_o,
  output logic       bus_rst_n_o,
  output logic       seq_done_o,
  output logic [1:0] state_o
);
  localparam int STABLE_CYC = 2 * CYC_PER_MS + 1;
  localparam int CORE_CYC   = (CORE_DLY < 4) ? 4 : ((CORE_DLY > 6) ? 6 : CORE_DLY);

  logic [2:0] sync_q;
  logic       pwr_s, align_s, link_s;

  por_sync #(.WIDTH(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({link_done_i, clk_align_i, pwr_stable_i}),
    .q_o   (sync_q)
  );
  assign pwr_s   = sync_q[0];
  assign align_s = sync_q[1];
  assign link_s  = sync_q[2];

  seq_state_t state;
  logic pg_q, sys_n_q, core_q, bus_n_q, aligned_q, bus_exp_q;
  logic stable_en, ms_en, core_en;
  logic stable_hit, ms_hit, core_hit;
  logic bus_ok, core_fin, bus_fin;

  assign stable_en = pwr_s && (state == ST_WAIT_PWR);
  assign ms_en     = pwr_s && ((state == ST_SYS_HOLD) ||
                               ((state == ST_RELEASE) && !bus_exp_q));
  assign core_en   = pwr_s && (state == ST_RELEASE) && core_q && (aligned_q || align_s);

  por_timer #(.LIMIT(STABLE_CYC)) u_stable_tmr (
    .clk (clk), .rst_n (rst_n), .clr (!pwr_s), .en (stable_en), .hit (stable_hit)
  );

  // one millisecond timer, reused for the system hold and then the bus wait
  por_timer #(.LIMIT(CYC_PER_MS)) u_ms_tmr (
    .clk (clk), .rst_n (rst_n), .clr (!pwr_s), .en (ms_en), .hit (ms_hit)
  );

  por_timer #(.LIMIT(CORE_CYC)) u_core_tmr (
    .clk (clk), .rst_n (rst_n), .clr (!pwr_s), .en (core_en), .hit (core_hit)
  );

  assign bus_ok   = (ms_hit || bus_exp_q) && link_s;
  assign core_fin = !core_q || core_hit;
  assign bus_fin  = bus_n_q || bus_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_WAIT_PWR;
      pg_q      <= 1'b0;
      sys_n_q   <= 1'b0;
      core_q    <= 1'b1;
      bus_n_q   <= 1'b0;
      aligned_q <= 1'b0;
      bus_exp_q <= 1'b0;
    end else if (!pwr_s) begin
      state     <= ST_WAIT_PWR;
      pg_q      <= 1'b0;
      sys_n_q   <= 1'b0;
      core_q    <= 1'b1;
      bus_n_q   <= 1'b0;
      aligned_q <= 1'b0;
      bus_exp_q <= 1'b0;
    end else begin
      unique case (state)
        ST_WAIT_PWR: begin
          if (stable_hit) begin
            pg_q  <= 1'b1;
            state <= ST_SYS_HOLD;
          end
        end
        ST_SYS_HOLD: begin
          if (ms_hit) begin
            sys_n_q <= 1'b1;
            state   <= ST_RELEASE;
          end
        end
        ST_RELEASE: begin
          if (align_s)  aligned_q <= 1'b1;
          if (ms_hit)   bus_exp_q <= 1'b1;
          if (core_hit) core_q    <= 1'b0;
          if (bus_ok)   bus_n_q   <= 1'b1;
          if (core_fin && bus_fin) state <= ST_DONE;
        end
        ST_DONE: begin
          state <= ST_DONE;
        end
        default: state <= ST_WAIT_PWR;
      endcase
    end
  end

  assign pwr_good_o  = pg_q;
  assign sys_rst_n_o = sys_n_q;
  assign core_rst_o  = core_q;
  assign bus_rst_n_o = bus_n_q;
  assign seq_done_o  = pg_q && sys_n_q && !core_q && bus_n_q;
  assign state_o     = state;
endmodule

// File: rtl/por_sequencer_chk.sv
module por_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_stable_i,
  input logic       pwr_good_o,
  input logic       sys_rst_n_o,
  input logic       core_rst_o,
  input logic       bus_rst_n_o,
  input logic       seq_done_o,
  input logic [1:0] state_o
);
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 3'd4) age <= age + 3'd1;
  end

  p_sys_after_pg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_n_o |-> pwr_good_o);

  p_core_after_sys_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_o |-> sys_rst_n_o);

  p_bus_after_sys_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_n_o |-> sys_rst_n_o);

  p_done_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done_o == (state_o == 2'd3));

  p_pg_from_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good_o) |-> $past(state_o) == 2'd0);

  p_power_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((age == 3'd4) && !$past(pwr_stable_i, 3)) |->
      (!pwr_good_o && !sys_rst_n_o && core_rst_o && !bus_rst_n_o && state_o == 2'd0));
endmodule

bind por_sequencer por_sequencer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_stable_i (pwr_stable_i),
  .pwr_good_o   (pwr_good_o),
  .sys_rst_n_o  (sys_rst_n_o),
  .core_rst_o   (core_rst_o),
  .bus_rst_n_o  (bus_rst_n_o),
  .seq_done_o   (seq_done_o),
  .state_o      (state_o)
);

// File: tb/test_por_sequencer.sv
`timescale 1ns/1ps
module test_por_sequencer;
  localparam int MS   = 8;
  localparam int DLY  = 5;
  localparam int STAB = 2 * MS + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr = 1'b0, align = 1'b0, link = 1'b0;
  logic pg, sys_n, core, bus_n, done;
  logic [1:0] st;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  por_sequencer #(.CYC_PER_MS(MS), .CORE_DLY(DLY)) i_por_sequencer (
    .clk (clk), .rst_n (rst_n), .pwr_stable_i (pwr), .clk_align_i (align),
    .link_done_i (link), .pwr_good_o (pg), .sys_rst_n_o (sys_n),
    .core_rst_o (core), .bus_rst_n_o (bus_n), .seq_done_o (done), .state_o (st)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_pg(output int n);
    n = 0;
    while (!pg && n < 200) begin step(); n++; end
  endtask

  task automatic wait_sys(output int n);
    n = 0;
    while (!sys_n && n < 200) begin step(); n++; end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic drop_power();
    pwr = 1'b0;
    step(); step();
    chk("R7 pg held two cycles after loss", int'(pg), 1);
    step();
    chk("R7 all asserted after loss", int'({pg, sys_n, core, bus_n}), 4'b0010);
    chk("R7 state back to wait", int'(st), 0);
    step(); step();
  endtask

  task automatic run_seq(input int a, input int l);
    int n, ci, bi, di;
    align = 1'b0; link = 1'b0; pwr = 1'b1;
    wait_pg(n);
    chk("R1 power-good delay", n, 2 * MS + 3);
    wait_sys(n);
    chk("R2 system reset delay", n, MS);
    ci = -1; bi = -1; di = -1;
    for (int i = 0; i < 24; i++) begin
      if (!core && ci < 0) ci = i;
      if (bus_n && bi < 0) bi = i;
      if (done && di < 0) di = i;
      align = (i == a);
      link  = (i >= l);
      step();
    end
    align = 1'b0;
    chk("R3 R4 core release cycle", ci, a + 2 + DLY);
    chk("R5 bus release cycle", bi, mx(MS, l + 3));
    chk("R6 done cycle", di, mx(a + 2 + DLY, mx(MS, l + 3)));
    chk("R6 final state", int'(st), 3);
    drop_power();
  endtask

  initial begin
    int n;
    step(); step();
    chk("R8 reset outputs", int'({pg, sys_n, core, bus_n, done}), 5'b00100);
    chk("R8 reset state", int'(st), 0);
    rst_n = 1'b1;
    step();
    // early strobe during the hold phase must not count toward core release
    pwr = 1'b1; align = 1'b1;
    wait_pg(n);
    chk("R1 power-good delay", n, 2 * MS + 3);
    align = 1'b0;
    for (int i = 0; i < MS + 8; i++) step();
    chk("R3 core held without release-phase strobe", int'(core), 1);
    chk("R6 state stays in release", int'(st), 2);
    drop_power();
    // power glitch in the stable count restarts it
    pwr = 1'b1;
    for (int i = 0; i < 10; i++) step();
    pwr = 1'b0; step(); pwr = 1'b1;
    wait_pg(n);
    chk("R1 glitch restarts stable count", n, 2 * MS + 3);
    drop_power();
    for (int a = 0; a <= 6; a++)
      for (int l = 0; l <= 12; l++)
        run_seq(a, l);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule